// File: doc/BRIEF.md
# Serial Synthesizer Configuration Loader

This block takes a three-wire serial programming stream and turns it into the parallel settings for a two-channel frequency synthesizer. The two channels are a low band and a high band. The three wires are a bit clock, a data line and a load strobe. All three are treated as synchronous to the system clock and are sampled on it. Each rising edge of the bit clock pushes one data bit into a 20-bit frame register. The most significant bit is sent first.

When the load strobe rises, the two lowest frame bits act as an address. They pick one of four configuration words, and the upper 18 bits of the frame are written into that word:
- the low-band reference word,
- the high-band reference word,
- the low-band main/swallow word,
- the high-band main/swallow word.

Each channel also has a synchronous powerdown flag. It is derived from one bit of that channel's reference word and one bit of its main word.

The four words feed the divider and mode logic of the synthesizer. The powerdown flags gate that channel's circuitry.

Top module: `synth_cfg_loader`

## Requirements
- R1: While reset is asserted and after it, all four words read zero, except that bit 17 of each main word is 1. As a result, both powerdown outputs read 1.
- R2: A data bit is shifted into the frame register only in a system-clock cycle where `ser_clk` is sampled high after being low. The bit enters at the LSB end, so the first bit sent ends up as frame bit 19. When there is no such edge, `ser_dat` has no effect.
- R3: When `ser_le` rises, frame bits [19:2] are copied into one word, selected by frame bits [1:0]:
  - 00 selects the low-band reference word,
  - 01 selects the high-band reference word,
  - 10 selects the low-band main word,
  - 11 selects the high-band main word.
- R4: A load changes only the selected word. The other three words keep their values.
- R5: A loaded word appears on its output port at the first system-clock edge after the cycle in which the `ser_le` rise is sampled.
- R6: A load always uses the last 20 bits shifted in, however many bit clocks came before the strobe. This includes bits left over from earlier frames.
- R7: A channel's powerdown output is 1 exactly when bit 15 of its reference word is 0 and bit 17 of its main word is 1. These are frame bits 17 and 19.
- R8: Holding `ser_le` high gives one load only. Bits shifted while it stays high are not written until the next rise of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock (sampled) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, acts on its rising edge |
| if_ref_word | output | 18 | Low-band reference word |
| rf_ref_word | output | 18 | High-band reference word |
| if_main_word | output | 18 | Low-band main/swallow word |
| rf_main_word | output | 18 | High-band main/swallow word |
| if_pwrdn | output | 1 | Low-band synchronous powerdown |
| rf_pwrdn | output | 1 | High-band synchronous powerdown |

## Verification
A wrong internal state cannot hide for long:
- **Frame register:** if it is corrupted or misaligned, the next strobe writes a wrong word, or writes the wrong word address. This shows on a port one clock after the strobe.
- **Latches:** a latch that drifts or is written by mistake is caught by comparing all four words after every load. That includes the words that should not have changed.
- **Powerdown flags:** these follow the words with no delay, so a wrong flag shows in the same cycle as the word that drives it.

// File: rtl/scl_pkg.sv
package scl_pkg;
    localparam int unsigned SCL_CTRL_W  = 2;
    localparam int unsigned SCL_N_WORDS = 4;
    localparam int unsigned SCL_N_CHAN  = 2;
    // word addresses; reference words at 0..1, main words at 2..3
    localparam int unsigned SCL_REF_BASE  = 0;
    localparam int unsigned SCL_MAIN_BASE = 2;
endpackage

// File: rtl/scl_shifter.sv
module scl_shifter #(
    parameter int unsigned FRAME_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_le,
    output logic [FRAME_W-1:0] frame,
    output logic               load
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               sclk;
        logic               le;
    } sh_t;

    sh_t sh_d, sh_q;
    logic shift_en;

    always_comb begin
        sh_d      = sh_q;
        shift_en  = ser_clk & ~sh_q.sclk;
        load      = ser_le & ~sh_q.le;
        sh_d.sclk = ser_clk;
        sh_d.le   = ser_le;
        if (shift_en) begin
            sh_d.sr = {sh_q.sr[FRAME_W-2:0], ser_dat};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign frame = sh_q.sr;

    // R2: a sampled rising bit clock places the data bit at the LSB end
    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sh_q.sr[0] == $past(ser_dat)));
    // R2: without a bit-clock edge the frame is left alone
    a_r2_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sh_q.sr));
    // R8: a strobe held high yields no further load
    a_r8_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_le && sh_q.le) |-> !load);
endmodule

// File: rtl/scl_latch_bank.sv
module scl_latch_bank
    import scl_pkg::*;
#(
    parameter int unsigned FRAME_W     = 20,
    parameter int unsigned MAIN_PD_BIT = 19
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [FRAME_W-1:0]                           frame,
    input  logic                                         load,
    output logic [SCL_N_WORDS-1:0][FRAME_W-SCL_CTRL_W-1:0] words
);
    localparam int unsigned PAY_W = FRAME_W - SCL_CTRL_W;

    typedef struct packed {
        logic [SCL_N_WORDS-1:0][PAY_W-1:0] w;
    } lb_t;

    lb_t  lb_d, lb_q;
    logic [SCL_N_WORDS-1:0] wr_en;
    logic [PAY_W-1:0]       payload;
    logic [SCL_N_WORDS-1:0][PAY_W-1:0] rst_val;

    assign payload = frame[FRAME_W-1:SCL_CTRL_W];

    for (genvar i = 0; i < SCL_N_WORDS; i++) begin : g_word
        localparam logic [SCL_CTRL_W-1:0] ADDR = SCL_CTRL_W'(i);
        assign wr_en[i] = load && (frame[SCL_CTRL_W-1:0] == ADDR);
        if (i >= SCL_MAIN_BASE) begin : g_main
            assign rst_val[i] = PAY_W'(1) << (MAIN_PD_BIT - SCL_CTRL_W);
        end else begin : g_ref
            assign rst_val[i] = '0;
        end

        // R4: an unselected word keeps its value
        a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[i] |=> $stable(lb_q.w[i]));
        // R3: the selected word takes the payload of the frame
        a_r3_write: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[i] |=> (lb_q.w[i] == $past(payload)));
    end

    always_comb begin
        lb_d = lb_q;
        for (int i = 0; i < SCL_N_WORDS; i++) begin
            if (wr_en[i]) begin
                lb_d.w[i] = payload;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lb_q.w <= rst_val;
        end else begin
            lb_q <= lb_d;
        end
    end

    assign words = lb_q.w;

    // R3: one frame addresses exactly one word
    a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));
endmodule

// File: rtl/scl_pwrdn.sv
module scl_pwrdn
    import scl_pkg::*;
#(
    parameter int unsigned PAY_W      = 18,
    parameter int unsigned REF_EN_POS = 15,
    parameter int unsigned MAIN_PD_POS = 17
) (
    input  logic [SCL_N_WORDS-1:0][PAY_W-1:0] words,
    output logic [SCL_N_CHAN-1:0]             pwrdn
);
    for (genvar c = 0; c < SCL_N_CHAN; c++) begin : g_chan
        logic ref_active;
        logic main_req;
        assign ref_active = words[SCL_REF_BASE + c][REF_EN_POS];
        assign main_req   = words[SCL_MAIN_BASE + c][MAIN_PD_POS];
        assign pwrdn[c]   = main_req & ~ref_active;
    end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import scl_pkg::*;
#(
    parameter int unsigned FRAME_W     = 20,
    parameter int unsigned REF_EN_BIT  = 17,
    parameter int unsigned MAIN_PD_BIT = 19
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ser_clk,
    input  logic                          ser_dat,
    input  logic                          ser_le,
    output logic [FRAME_W-SCL_CTRL_W-1:0] if_ref_word,
    output logic [FRAME_W-SCL_CTRL_W-1:0] rf_ref_word,
    output logic [FRAME_W-SCL_CTRL_W-1:0] if_main_word,
    output logic [FRAME_W-SCL_CTRL_W-1:0] rf_main_word,
    output logic                          if_pwrdn,
    output logic                          rf_pwrdn
);
    localparam int unsigned PAY_W = FRAME_W - SCL_CTRL_W;

    logic [FRAME_W-1:0]                frame;
    logic                              load;
    logic [SCL_N_WORDS-1:0][PAY_W-1:0] words;
    logic [SCL_N_CHAN-1:0]             pwrdn;

    scl_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .ser_le  (ser_le),
        .frame   (frame),
        .load    (load)
    );

    scl_latch_bank #(.FRAME_W(FRAME_W), .MAIN_PD_BIT(MAIN_PD_BIT)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .frame (frame),
        .load  (load),
        .words (words)
    );

    scl_pwrdn #(
        .PAY_W       (PAY_W),
        .REF_EN_POS  (REF_EN_BIT - SCL_CTRL_W),
        .MAIN_PD_POS (MAIN_PD_BIT - SCL_CTRL_W)
    ) u_pd (
        .words (words),
        .pwrdn (pwrdn)
    );

    assign if_ref_word  = words[SCL_REF_BASE];
    assign rf_ref_word  = words[SCL_REF_BASE + 1];
    assign if_main_word = words[SCL_MAIN_BASE];
    assign rf_main_word = words[SCL_MAIN_BASE + 1];
    assign if_pwrdn     = pwrdn[0];
    assign rf_pwrdn     = pwrdn[1];

    // R5: with no strobe rise the outputs are held
    a_r5_no_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(if_ref_word) && $stable(rf_ref_word)
                   && $stable(if_main_word) && $stable(rf_main_word)));
    // R7: a powerdown flag only moves when some word moved
    a_r7_pd_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(if_pwrdn) && $stable(rf_pwrdn)));
endmodule

// File: tb/sim_synth_cfg_loader.sv
module sim_synth_cfg_loader;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 20;
    localparam int PW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [PW-1:0] if_ref_word, rf_ref_word, if_main_word, rf_main_word;
    logic if_pwrdn, rf_pwrdn;

    int n_chk = 0;
    int n_bad = 0;
    logic [FW-1:0] m_sr = '0;
    logic [PW-1:0] exp_w [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_cfg_loader u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_le(ser_le), .if_ref_word(if_ref_word), .rf_ref_word(rf_ref_word),
        .if_main_word(if_main_word), .rf_main_word(rf_main_word),
        .if_pwrdn(if_pwrdn), .rf_pwrdn(rf_pwrdn)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmp(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic e_if_pd, e_rf_pd;
        e_if_pd = ~exp_w[0][15] & exp_w[2][17];
        e_rf_pd = ~exp_w[1][15] & exp_w[3][17];
        cmp({tag, " if_ref"},  if_ref_word,  exp_w[0]);
        cmp({tag, " rf_ref"},  rf_ref_word,  exp_w[1]);
        cmp({tag, " if_main"}, if_main_word, exp_w[2]);
        cmp({tag, " rf_main"}, rf_main_word, exp_w[3]);
        cmp({"R7 ", tag, " if_pwrdn"}, PW'(if_pwrdn), PW'(e_if_pd));
        cmp({"R7 ", tag, " rf_pwrdn"}, PW'(rf_pwrdn), PW'(e_rf_pd));
    endtask

    task automatic shift_bit(input logic b);
        ser_dat = b;
        tick(1);
        ser_clk = 1'b1;
        tick(2);
        ser_clk = 1'b0;
        tick(1);
        m_sr = {m_sr[FW-2:0], b};
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    endtask

    task automatic strobe(input string tag);
        ser_le = 1'b1;
        tick(1);
        exp_w[m_sr[1:0]] = m_sr[FW-1:2];
        check_all({"R5 ", tag});
        tick(1);
        ser_le = 1'b0;
        tick(1);
    endtask

    task automatic send(input logic [PW-1:0] pay, input logic [1:0] addr, input string tag);
        shift_bits({12'd0, pay, addr}, FW);
        strobe(tag);
    endtask

    task automatic t_reset;
        exp_w[0] = '0; exp_w[1] = '0;
        exp_w[2] = 18'h20000; exp_w[3] = 18'h20000;
        check_all("R1 reset");
    endtask

    task automatic t_each_target;
        send(18'h12345, 2'b00, "R3 if_ref");
        send(18'h0ABCD, 2'b01, "R3 rf_ref");
        send(18'h3C3C3, 2'b10, "R3 if_main");
        send(18'h15A5A, 2'b11, "R3 rf_main");
    endtask

    task automatic t_hold_others;
        send(18'h2FFFF, 2'b01, "R4 rf_ref only");
        check_all("R4 after");
    endtask

    task automatic t_long_short;
        shift_bits(32'h5, 5);
        send(18'h01234, 2'b10, "R6 long");
        shift_bits(32'h1B, 5);
        strobe("R6 short");
    endtask

    task automatic t_pd;
        send(18'h20000, 2'b10, "R7 if main pd");
        send(18'h00000, 2'b00, "R7 if ref off");
        send(18'h08000, 2'b00, "R7 if ref on");
        send(18'h00000, 2'b11, "R7 rf main no pd");
        send(18'h20000, 2'b11, "R7 rf main pd");
        send(18'h00000, 2'b01, "R7 rf ref off");
    endtask

    task automatic t_le_held;
        shift_bits({12'd0, 18'h11111, 2'b00}, FW);
        ser_le = 1'b1;
        tick(1);
        exp_w[m_sr[1:0]] = m_sr[FW-1:2];
        check_all("R8 first load");
        shift_bits({12'd0, 18'h22222, 2'b00}, FW);
        check_all("R8 held no reload");
        ser_le = 1'b0;
        tick(1);
        strobe("R8 next rise");
    endtask

    task automatic t_dat_ignored;
        ser_dat = 1'b1; tick(3); ser_dat = 1'b0; tick(3);
        strobe("R2 data without edge");
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_each_target();
        t_hold_others();
        t_long_short();
        t_pd();
        t_le_held();
        t_dat_ignored();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule